// File: doc/BRIEF.md
# Banked Local Share Memory with Owner-Exclusive Writes

This block is a 16 KiB scratch memory that serves the threads of one compute cluster. The storage is 1024 entries of 128 bits, spread over four independent banks of 256 entries. Up to four requesters present a request in the same cycle. Each request carries a thread number, an entry index, a write flag and write data. Any thread may read any entry. The address space is cut into equal regions, one per thread, and a write lands only when the requesting thread owns the region it targets.

Requests that reach different banks are granted together. Requests that meet in one bank are granted one per cycle, and the lowest-numbered requester goes first. A requester that is not granted keeps its request up until its ready goes high. Writes are answered one cycle after the grant with an acknowledge or a fault. A faulted write leaves the memory untouched. Reads return their data two cycles after the grant.

Each requester has a write-response state machine with three states: `WR_IDLE`, `WR_ACK` and `WR_FAULT`. It moves on every clock edge:
- A granted write with a matching owner moves it to `WR_ACK`.
- A granted write with a mismatched owner moves it to `WR_FAULT`.
- Any other cycle moves it to `WR_IDLE`.

Reset forces `WR_IDLE`.

Top module: `lsm_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all write-response and read-response valid outputs are low.
- R2: Entry index bits [1:0] select the bank and bits [9:2] select the row within that bank, giving 1024 distinct 128-bit entries. Data written to every index reads back unchanged.
- R3: A read returns the stored data whatever the requesting thread number.
- R4: A granted write whose thread number equals entry index bits [9:8] updates the entry. In the next cycle it shows write-response valid high and fault low.
- R5: A granted write whose thread number differs from index bits [9:8] shows write-response valid and fault both high in the next cycle. The entry keeps its old contents.
- R6: A valid request is granted (ready high) in the same cycle when no lower-numbered valid request targets the same bank. Requests to distinct banks are therefore granted together.
- R7: When several valid requests target one bank, only the lowest-numbered one is granted in that cycle.
- R8: A read granted in cycle C shows read-response valid with the entry's data in cycle C+2. Read-response valid is never high without such a grant.
- R9: A read granted in the cycle after a granted write to the same entry returns the newly written data.
- R10: In every cycle with at least one valid request, at least one request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request present, one bit per requester |
| req_ready | output | NPORT | Request granted this cycle |
| req_tid | input | NPORT x TIDW | Thread number of each request |
| req_addr | input | NPORT x AW | Entry index of each request |
| req_we | input | NPORT | 1 = write, 0 = read |
| req_wdata | input | NPORT x DW | Write data |
| wr_rsp_valid | output | NPORT | Write response present |
| wr_rsp_fault | output | NPORT | Write refused (ownership mismatch) |
| rd_rsp_valid | output | NPORT | Read data present |
| rd_rsp_data | output | NPORT x DW | Read data |

## Verification
The hardest case to reach from the ports is a write and a read of the same entry in back-to-back cycles while other requesters contend for that bank. A refused write followed by a read that must still see the old contents is almost as hard. The bench first fills every entry through owner writes, so every later read has a known value. Directed sequences then stage the fault-then-read and write-then-read pairs, and a four-way pile-up on one bank in which each requester holds its request until granted. A long seeded random phase follows, with thread numbers biased toward the owner. It produces mixed conflicts, acknowledges and faults, and a bench model predicts grants and responses cycle by cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    // per-requester write response state
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_ACK   = 2'd1,
        WR_FAULT = 2'd2
    } wr_rsp_e;
endpackage

// File: rtl/lsm_arb.sv
module lsm_arb #(
    parameter int NPORT = 4,
    parameter int BW    = 2
) (
    input  logic [NPORT-1:0]         valid,
    input  logic [NPORT-1:0][BW-1:0] bank,
    output logic [NPORT-1:0]         gnt
);
    // fixed priority per bank: a lower index with the same bank blocks
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NPORT-1:0] clash;
        always_comb begin
            clash = '0;
            for (int q = 0; q < p; q++) begin
                clash[q] = valid[q] && (bank[q] == bank[p]);
            end
        end
        assign gnt[p] = valid[p] && (clash == '0);
    end
endmodule

// File: rtl/lsm_bank.sv
module lsm_bank #(
    parameter int DEPTH = 256,
    parameter int DW    = 128
) (
    input  logic                     clk,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] row,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                cells[row] <= wdata;
            end else begin
                rdata <= cells[row];
            end
        end
    end
endmodule

// File: rtl/lsm_top.sv
module lsm_top
    import lsm_pkg::*;
#(
    parameter  int NPORT   = 4,
    parameter  int NBANK   = 4,
    parameter  int DEPTH   = 256,
    parameter  int DW      = 128,
    parameter  int NTHREAD = 4,
    localparam int BW      = $clog2(NBANK),
    localparam int RW      = $clog2(DEPTH),
    localparam int AW      = BW + RW,
    localparam int TIDW    = (NTHREAD > 1) ? $clog2(NTHREAD) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    output logic [NPORT-1:0]          req_ready,
    input  logic [NPORT-1:0][TIDW-1:0] req_tid,
    input  logic [NPORT-1:0][AW-1:0]  req_addr,
    input  logic [NPORT-1:0]          req_we,
    input  logic [NPORT-1:0][DW-1:0]  req_wdata,
    output logic [NPORT-1:0]          wr_rsp_valid,
    output logic [NPORT-1:0]          wr_rsp_fault,
    output logic [NPORT-1:0]          rd_rsp_valid,
    output logic [NPORT-1:0][DW-1:0]  rd_rsp_data
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    // request decode
    logic [NPORT-1:0][BW-1:0] bank_sel;
    logic [NPORT-1:0][RW-1:0] row_sel;
    logic [NPORT-1:0]         own_ok;

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            bank_sel[p] = req_addr[p][BW-1:0];
            row_sel[p]  = req_addr[p][AW-1:BW];
            own_ok[p]   = (req_tid[p] == req_addr[p][AW-1 -: TIDW]);
        end
    end

    lsm_arb #(.NPORT(NPORT), .BW(BW)) u_arb (
        .valid (req_valid),
        .bank  (bank_sel),
        .gnt   (req_ready)
    );

    // bank steering: each bank takes the one granted port aimed at it
    logic [NBANK-1:0]         b_en;
    logic [NBANK-1:0]         b_we;
    logic [NBANK-1:0][DW-1:0] b_rdata;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic          hit;
        logic [PW-1:0] who;
        always_comb begin
            hit = 1'b0;
            who = '0;
            for (int p = NPORT - 1; p >= 0; p--) begin
                if (req_ready[p] && (bank_sel[p] == BW'(b))) begin
                    hit = 1'b1;
                    who = PW'(p);
                end
            end
        end
        // a refused write never enables the bank
        assign b_en[b] = hit && (!req_we[who] || own_ok[who]);
        assign b_we[b] = req_we[who];

        lsm_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk   (clk),
            .en    (b_en[b]),
            .we    (b_we[b]),
            .row   (row_sel[who]),
            .wdata (req_wdata[who]),
            .rdata (b_rdata[b])
        );
    end

    // state register: write-response FSM and read pipeline stage 1
    wr_rsp_e                  wr_state [NPORT];
    logic [NPORT-1:0]         rd_stage1;
    logic [NPORT-1:0][BW-1:0] rd_bank1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORT; p++) begin
                wr_state[p] <= WR_IDLE;
            end
            rd_stage1 <= '0;
            rd_bank1  <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (req_ready[p] && req_we[p]) begin
                    wr_state[p] <= own_ok[p] ? WR_ACK : WR_FAULT;
                end else begin
                    wr_state[p] <= WR_IDLE;
                end
                rd_stage1[p] <= req_ready[p] && !req_we[p];
                rd_bank1[p]  <= bank_sel[p];
            end
        end
    end

    // outputs
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            unique case (wr_state[p])
                WR_ACK:   begin wr_rsp_valid[p] = 1'b1; wr_rsp_fault[p] = 1'b0; end
                WR_FAULT: begin wr_rsp_valid[p] = 1'b1; wr_rsp_fault[p] = 1'b1; end
                default:  begin wr_rsp_valid[p] = 1'b0; wr_rsp_fault[p] = 1'b0; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_rsp_valid <= '0;
            rd_rsp_data  <= '0;
        end else begin
            rd_rsp_valid <= rd_stage1;
            for (int p = 0; p < NPORT; p++) begin
                rd_rsp_data[p] <= b_rdata[rd_bank1[p]];
            end
        end
    end
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk #(
    parameter int NPORT   = 4,
    parameter int NBANK   = 4,
    parameter int DEPTH   = 256,
    parameter int NTHREAD = 4
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic [NPORT-1:0]                         req_valid,
    input logic [NPORT-1:0]                         req_ready,
    input logic [NPORT-1:0][((NTHREAD > 1) ? $clog2(NTHREAD) : 1)-1:0] req_tid,
    input logic [NPORT-1:0][$clog2(NBANK)+$clog2(DEPTH)-1:0] req_addr,
    input logic [NPORT-1:0]                         req_we,
    input logic [NPORT-1:0]                         wr_rsp_valid,
    input logic [NPORT-1:0]                         wr_rsp_fault,
    input logic [NPORT-1:0]                         rd_rsp_valid
);
    localparam int BW   = $clog2(NBANK);
    localparam int AW   = BW + $clog2(DEPTH);
    localparam int TIDW = (NTHREAD > 1) ? $clog2(NTHREAD) : 1;

    // R10: someone is always served
    a_r10_some_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid != '0) |-> ($countones(req_ready) >= 1));

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        // R6: ready only for a present request
        a_r6_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            req_ready[p] |-> req_valid[p]);

        // R4: owner write acknowledged next cycle
        a_r4_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[p] && req_we[p] && (req_tid[p] == req_addr[p][AW-1 -: TIDW]))
            |=> (wr_rsp_valid[p] && !wr_rsp_fault[p]));

        // R5: foreign write faulted next cycle
        a_r5_fault_next: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[p] && req_we[p] && (req_tid[p] != req_addr[p][AW-1 -: TIDW]))
            |=> (wr_rsp_valid[p] && wr_rsp_fault[p]));

        // R8: read data two cycles after grant
        a_r8_read_two: assert property (@(posedge clk) disable iff (!rst_n)
            (req_ready[p] && !req_we[p]) |-> ##2 rd_rsp_valid[p]);

        // R8: no read response without a grant
        a_r8_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
            rd_rsp_valid[p] |-> $past(req_ready[p] && !req_we[p], 2));

        // R7: the lower requester wins a shared bank
        for (genvar q = 0; q < p; q++) begin : g_q
            a_r7_lower_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid[q] && req_valid[p] &&
                 (req_addr[q][BW-1:0] == req_addr[p][BW-1:0])) |-> !req_ready[p]);
        end
    end
endmodule

bind lsm_top lsm_chk #(
    .NPORT(NPORT), .NBANK(NBANK), .DEPTH(DEPTH), .NTHREAD(NTHREAD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_tid      (req_tid),
    .req_addr     (req_addr),
    .req_we       (req_we),
    .wr_rsp_valid (wr_rsp_valid),
    .wr_rsp_fault (wr_rsp_fault),
    .rd_rsp_valid (rd_rsp_valid)
);

// File: tb/lsm_top_tb.sv
`timescale 1ns/1ps
module lsm_top_tb;
    localparam int NP = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      req_valid = '0;
    logic [NP-1:0]      req_ready;
    logic [NP-1:0][1:0] req_tid = '0;
    logic [NP-1:0][9:0] req_addr = '0;
    logic [NP-1:0]      req_we = '0;
    logic [NP-1:0][127:0] req_wdata = '0;
    logic [NP-1:0]      wr_rsp_valid, wr_rsp_fault, rd_rsp_valid;
    logic [NP-1:0][127:0] rd_rsp_data;

    always #2.5 clk = ~clk;

    lsm_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_tid(req_tid), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .wr_rsp_valid(wr_rsp_valid), .wr_rsp_fault(wr_rsp_fault),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    string rd_tag = "R8";

    // bench model
    logic [127:0] model [1024];
    logic [NP-1:0][1:0]   n_tid;
    logic [NP-1:0][9:0]   n_addr;
    logic [NP-1:0]        n_valid, n_we;
    logic [NP-1:0][127:0] n_wd;
    logic [NP-1:0]        ewv, ewf, erv1, erv2;
    logic [NP-1:0][127:0] erd1, erd2;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] model_gnt(input logic [NP-1:0] v, input logic [NP-1:0][9:0] a);
        logic [NP-1:0] g = '0;
        for (int p = 0; p < NP; p++) begin
            logic blk = 1'b0;
            for (int q = 0; q < p; q++) if (v[q] && a[q][1:0] == a[p][1:0]) blk = 1'b1;
            g[p] = v[p] && !blk;
        end
        return g;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic step();
        logic [NP-1:0] g;
        logic conflict;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(wr_rsp_valid[p] == ewv[p] && (!ewv[p] || wr_rsp_fault[p] == ewf[p]),
                ewf[p] ? "R5 write response" : "R4 write response",
                128'({wr_rsp_valid[p], wr_rsp_fault[p]}), 128'({ewv[p], ewf[p]}));
            chk(rd_rsp_valid[p] == erv2[p] && (!erv2[p] || rd_rsp_data[p] == erd2[p]),
                {rd_tag, " read response"}, rd_rsp_data[p], erd2[p]);
        end
        erv2 = erv1;
        erd2 = erd1;
        req_valid = n_valid; req_tid = n_tid; req_addr = n_addr; req_we = n_we; req_wdata = n_wd;
        #1;
        g = model_gnt(n_valid, n_addr);
        conflict = (g != n_valid);
        chk(req_ready == g, conflict ? "R7 grant" : "R6 grant", 128'(req_ready), 128'(g));
        if (n_valid != '0) chk(req_ready != '0, "R10 progress", 128'(req_ready), 128'(g));
        for (int p = 0; p < NP; p++) begin
            erv1[p] = g[p] && !n_we[p];
            erd1[p] = model[n_addr[p]];
            ewv[p]  = g[p] && n_we[p];
            ewf[p]  = g[p] && n_we[p] && (n_tid[p] != n_addr[p][9:8]);
        end
        for (int p = 0; p < NP; p++)
            if (g[p] && n_we[p] && n_tid[p] == n_addr[p][9:8]) model[n_addr[p]] = n_wd[p];
    endtask

    task automatic idle_n(input int n);
        n_valid = '0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic one(input int p, input bit we, input logic [1:0] tid,
                       input logic [9:0] a, input logic [127:0] d);
        n_valid = '0; n_valid[p] = 1'b1;
        n_we[p] = we; n_tid[p] = tid; n_addr[p] = a; n_wd[p] = d;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        n_valid = '0; n_we = '0; n_tid = '0; n_addr = '0; n_wd = '0;
        ewv = '0; ewf = '0; erv1 = '0; erv2 = '0; erd1 = '0; erd2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_rsp_valid == '0 && rd_rsp_valid == '0, "R1 in reset",
            128'({wr_rsp_valid, rd_rsp_valid}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_rsp_valid == '0 && rd_rsp_valid == '0, "R1 after release",
            128'({wr_rsp_valid, rd_rsp_valid}), 128'(0));

        // R2: fill every entry by its owner, four banks at once, then read back
        rd_tag = "R2";
        for (int k = 0; k < 256; k++) begin
            for (int p = 0; p < NP; p++) begin
                n_addr[p] = 10'(4 * k + p);
                n_tid[p]  = n_addr[p][9:8];
                n_we[p]   = 1'b1;
                n_wd[p]   = rnd128();
            end
            n_valid = '1;
            step();
        end
        n_we = '0;
        for (int k = 0; k < 256; k++) begin
            for (int p = 0; p < NP; p++) begin
                n_addr[p] = 10'(4 * k + (3 - p));
                n_tid[p]  = 2'($urandom);
            end
            n_valid = '1;
            step();
        end
        idle_n(3);

        // R5 then R3: foreign write refused, other thread reads old value
        rd_tag = "R5";
        one(0, 1'b1, 2'd1, 10'd0, {4{32'hDEADBEEF}});
        one(2, 1'b0, 2'd3, 10'd0, '0);
        idle_n(3);
        rd_tag = "R3";
        one(1, 1'b0, 2'd0, 10'd1023, '0);
        one(3, 1'b0, 2'd2, 10'd300, '0);
        idle_n(3);

        // R9: write then read of same entry in the next cycle
        rd_tag = "R9";
        one(1, 1'b1, 2'd2, 10'd517, {4{32'hCAFEF00D}});
        one(3, 1'b0, 2'd0, 10'd517, '0);
        idle_n(3);

        // R7: four-way pile-up on bank 2, each holds until granted
        rd_tag = "R7";
        for (int p = 0; p < NP; p++) begin
            n_addr[p] = 10'(4 * (p + 10) + 2);
            n_we[p] = 1'b0;
            n_tid[p] = 2'(p);
        end
        n_valid = '1;
        for (int i = 0; i < NP; i++) begin
            step();
            n_valid = n_valid & ~req_ready;
        end
        idle_n(3);

        // random mix
        rd_tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NP; p++) begin
                n_valid[p] = ($urandom % 4) != 0;
                n_addr[p]  = 10'($urandom);
                n_we[p]    = $urandom % 2;
                n_tid[p]   = ($urandom % 3 == 0) ? 2'($urandom) : n_addr[p][9:8];
                n_wd[p]    = rnd128();
            end
            step();
        end
        idle_n(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule